// File: doc/BRIEF.md
# Sideband Inbound Request Receiver with Completion Responder

This block sits at the receive side of a sideband endpoint. Peer agents present requests on a valid/ready port. When the local processor's firmware has opened the port, the block latches the whole request into read-only registers: routing IDs, opcode, byte enables, address, extended header and up to two data words. It then raises a message-received status and an interrupt to the processor.

Firmware reads the latched request and writes the completion status and completion data. It then sets a completion trigger. That trigger retires the message. If the latched request was non-posted, the trigger also launches one completion on a valid/ready outbound port, addressed back to the requester's source port. Posted requests and inbound completions are retired without any outbound traffic.

The inbound port holds one request at a time. It stays closed while firmware owns a latched message or while a completion is still waiting to go out. Nothing already latched can therefore be overwritten.

Top module: `sb_inbound_responder`

## Requirements
- R1: After reset, all of the following are 0: every capture register, the access-enable bit, the mask bit, the received status, `irq`, `req_ready` and `cpl_valid`.
- R2: `req_ready` is 1 only when all three hold: access-enable (control word 6, bit 0) is 1, the received status is 0, and no completion is outstanding. While access-enable is 0, a valid request is neither accepted nor captured.
- R3: An accepted request is captured into these registers:
  - Word 0: bits 7:0 destination, 15:8 source, 23:16 opcode, 27:24 byte enables, 29:28 kind (01 posted, 10 non-posted, 11 completion).
  - Word 1: the lower address.
  - Word 2: bits 15:0 the upper address, bit 31 the address-length flag.
  - Word 3: bits 15:0 SAI, 19:16 root space, bit 31 header-present.
  - Words 4 and 5: the two data words.
- R4: The received status (word 6, bit 31) reads 1 from the cycle after acceptance. While it is 1, `req_ready` is 0, and a further request does not change the captured fields.
- R5: `irq` equals the received status when the mask bit (word 6, bit 1) is 0, and is 0 when the mask bit is 1. The mask never changes the status bit.
- R6: A write to word 7 with bit 31 set, while the status is 1 and the captured kind is non-posted, has three effects. It clears the status. It stores bits 2:0 as the completion code (000 success, 001 unsupported). From the next cycle it drives `cpl_valid` with that code, the word 8 data, the fixed completion SAI, and the captured source ID as destination.
- R7: The same trigger on a captured posted (01) or completion (11) request clears the status and produces no completion.
- R8: Word 7, bit 31 reads 1 while a completion is outstanding, and hardware clears it after the `cpl_valid`/`cpl_ready` handshake. While `cpl_valid` is 1, all completion outputs stay stable, and writes to the completion code or data are ignored.
- R9: A trigger write while the received status is 0 has no effect: no completion is produced and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Inbound request present |
| req_ready | output | 1 | Inbound request accepted this cycle |
| req_kind | input | 2 | 01 posted, 10 non-posted, 11 completion |
| req_dst | input | 8 | Destination port ID |
| req_src | input | 8 | Source port ID |
| req_opcode | input | 8 | Opcode |
| req_be | input | 4 | Byte enables |
| req_addr_lo | input | 32 | Lower address |
| req_addr_hi | input | 16 | Upper address |
| req_addr_wide | input | 1 | Upper address valid (long address form) |
| req_sai | input | 16 | Security attribute |
| req_rs | input | 4 | Root space |
| req_eh | input | 1 | Extended header present |
| req_data0 | input | 32 | First data word |
| req_data1 | input | 32 | Second data word |
| cpl_valid | output | 1 | Outbound completion present |
| cpl_ready | input | 1 | Outbound completion taken |
| cpl_dst | output | 8 | Completion destination (captured source) |
| cpl_code | output | 3 | Completion status code |
| cpl_data | output | 32 | Completion data word |
| cpl_sai | output | 8 | Fixed completion SAI |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Message-received interrupt |

## Verification
The bench goes after four corner cases.

First, it offers requests while the port is closed or while a message is still held. A design that ignored the gating would overwrite the header firmware is reading.

Second, it retires posted requests, completion-kind requests and requests with no message held. A design that did not check the captured kind would emit a spurious completion, and the scoreboard would flag it as unexpected.

Third, it stalls `cpl_ready` and rewrites the completion code and data during the stall. A design without the write protection would change a completion already on the wire.

Fourth, it toggles the mask and checks that the status bit survives while `irq` follows the mask.

// File: rtl/sbir_pkg.sv
package sbir_pkg;

   typedef enum logic [1:0] {
      KIND_NONE      = 2'b00,
      KIND_POSTED    = 2'b01,
      KIND_NONPOSTED = 2'b10,
      KIND_CPL       = 2'b11
   } rx_kind_e;

   localparam logic [2:0] CODE_SUCCESS     = 3'b000;
   localparam logic [2:0] CODE_UNSUPPORTED = 3'b001;

   // register word indices
   localparam int unsigned OFS_HDR     = 0;
   localparam int unsigned OFS_ADDR_LO = 1;
   localparam int unsigned OFS_ADDR_HI = 2;
   localparam int unsigned OFS_EXT     = 3;
   localparam int unsigned OFS_DATA0   = 4;
   localparam int unsigned OFS_DATA1   = 5;
   localparam int unsigned OFS_CTRL    = 6;
   localparam int unsigned OFS_CPL_CTL = 7;
   localparam int unsigned OFS_CPL_DAT = 8;

   localparam int unsigned TRIGGER_BIT = 31;

endpackage

// File: rtl/sbir_capture.sv
module sbir_capture
   import sbir_pkg::*;
#(
   parameter int PID_W    = 8,
   parameter int SAI_W    = 16,
   parameter int RS_W     = 4,
   parameter int AHI_W    = 16,
   parameter int DATA_W   = 32,
   parameter int NUM_DATA = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        in_kind,
   input  logic [PID_W-1:0]  in_dst,
   input  logic [PID_W-1:0]  in_src,
   input  logic [7:0]        in_opcode,
   input  logic [3:0]        in_be,
   input  logic [DATA_W-1:0] in_addr_lo,
   input  logic [AHI_W-1:0]  in_addr_hi,
   input  logic              in_wide,
   input  logic [SAI_W-1:0]  in_sai,
   input  logic [RS_W-1:0]   in_rs,
   input  logic              in_eh,
   input  logic [DATA_W-1:0] in_data0,
   input  logic [DATA_W-1:0] in_data1,
   output rx_kind_e          cap_kind,
   output logic [PID_W-1:0]  cap_dst,
   output logic [PID_W-1:0]  cap_src,
   output logic [7:0]        cap_opcode,
   output logic [3:0]        cap_be,
   output logic [DATA_W-1:0] cap_addr_lo,
   output logic [AHI_W-1:0]  cap_addr_hi,
   output logic              cap_wide,
   output logic [SAI_W-1:0]  cap_sai,
   output logic [RS_W-1:0]   cap_rs,
   output logic              cap_eh,
   output logic [DATA_W-1:0] cap_data0,
   output logic [DATA_W-1:0] cap_data1
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_kind    <= KIND_NONE;
         cap_dst     <= '0;
         cap_src     <= '0;
         cap_opcode  <= '0;
         cap_be      <= '0;
         cap_addr_lo <= '0;
         cap_addr_hi <= '0;
         cap_wide    <= 1'b0;
         cap_sai     <= '0;
         cap_rs      <= '0;
         cap_eh      <= 1'b0;
         cap_data0   <= '0;
      end else if (load) begin
         cap_kind    <= rx_kind_e'(in_kind);
         cap_dst     <= in_dst;
         cap_src     <= in_src;
         cap_opcode  <= in_opcode;
         cap_be      <= in_be;
         cap_addr_lo <= in_addr_lo;
         cap_addr_hi <= in_addr_hi;
         cap_wide    <= in_wide;
         cap_sai     <= in_sai;
         cap_rs      <= in_rs;
         cap_eh      <= in_eh;
         cap_data0   <= in_data0;
      end
   end

   generate
      if (NUM_DATA == 2) begin : g_two_words
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cap_data1 <= '0;
            else if (load) cap_data1 <= in_data1;
         end
      end else begin : g_one_word
         assign cap_data1 = '0;
      end
   endgenerate

endmodule

// File: rtl/sbir_ctrl.sv
module sbir_ctrl
   import sbir_pkg::*;
#(
   parameter int REG_AW = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              accept,
   input  logic              cpl_busy,
   input  rx_kind_e          rx_kind,
   output logic              access_en,
   output logic              irq_mask,
   output logic              rcv_sts,
   output logic [2:0]        cpl_code,
   output logic [DATA_W-1:0] cpl_word,
   output logic              start_cpl
);

   localparam logic [REG_AW-1:0] A_CTRL    = REG_AW'(OFS_CTRL);
   localparam logic [REG_AW-1:0] A_CPL_CTL = REG_AW'(OFS_CPL_CTL);
   localparam logic [REG_AW-1:0] A_CPL_DAT = REG_AW'(OFS_CPL_DAT);

   logic wr_ctrl, wr_cctl, wr_cdat, consume;

   assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
   assign wr_cctl   = wr_en && (wr_addr == A_CPL_CTL);
   assign wr_cdat   = wr_en && (wr_addr == A_CPL_DAT);
   assign consume   = wr_cctl && wdata[TRIGGER_BIT] && rcv_sts;
   assign start_cpl = consume && (rx_kind == KIND_NONPOSTED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         access_en <= 1'b0;
         irq_mask  <= 1'b0;
         rcv_sts   <= 1'b0;
         cpl_code  <= CODE_SUCCESS;
         cpl_word  <= '0;
      end else begin
         if (wr_ctrl) begin
            access_en <= wdata[0];
            irq_mask  <= wdata[1];
         end
         if (accept)       rcv_sts <= 1'b1;
         else if (consume) rcv_sts <= 1'b0;
         if (wr_cctl && !cpl_busy) cpl_code <= wdata[2:0];
         if (wr_cdat && !cpl_busy) cpl_word <= wdata;
      end
   end

   assert_accept_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> access_en);
   assert_status_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rcv_sts);
   assert_status_clears_by_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rcv_sts) |-> $past(wr_cctl && wdata[TRIGGER_BIT]));
   assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_busy |=> $stable(cpl_code) && $stable(cpl_word));

endmodule

// File: rtl/sbir_cpl_engine.sv
module sbir_cpl_engine (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic out_ready,
   output logic out_valid,
   output logic busy
);

   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pend <= 1'b0;
      else if (start)                 pend <= 1'b1;
      else if (pend && out_ready)     pend <= 1'b0;
   end

   assign out_valid = pend;
   assign busy      = pend;

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !start);
   assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !out_ready |=> pend);

endmodule

// File: rtl/sb_inbound_responder.sv
module sb_inbound_responder
   import sbir_pkg::*;
#(
   parameter int          PID_W     = 8,
   parameter int          SAI_W     = 16,
   parameter int          RS_W      = 4,
   parameter int          AHI_W     = 16,
   parameter int          DATA_W    = 32,
   parameter int          NUM_DATA  = 2,
   parameter int          CSAI_W    = 8,
   parameter logic [7:0]  CPL_SAI   = 8'hA5,
   parameter int          REG_AW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [PID_W-1:0]  req_dst,
   input  logic [PID_W-1:0]  req_src,
   input  logic [7:0]        req_opcode,
   input  logic [3:0]        req_be,
   input  logic [DATA_W-1:0] req_addr_lo,
   input  logic [AHI_W-1:0]  req_addr_hi,
   input  logic              req_addr_wide,
   input  logic [SAI_W-1:0]  req_sai,
   input  logic [RS_W-1:0]   req_rs,
   input  logic              req_eh,
   input  logic [DATA_W-1:0] req_data0,
   input  logic [DATA_W-1:0] req_data1,
   output logic              cpl_valid,
   input  logic              cpl_ready,
   output logic [PID_W-1:0]  cpl_dst,
   output logic [2:0]        cpl_code,
   output logic [DATA_W-1:0] cpl_data,
   output logic [CSAI_W-1:0] cpl_sai,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (DATA_W != 32)               begin : g_bad_data_w $error("register words are 32 bits"); end
      if (PID_W < 1 || PID_W > 8)     begin : g_bad_pid_w  $error("port ID must fit 8 bits"); end
      if (SAI_W < 1 || SAI_W > 16)    begin : g_bad_sai_w  $error("SAI must fit 16 bits"); end
      if (RS_W < 1 || RS_W > 4)       begin : g_bad_rs_w   $error("root space must fit 4 bits"); end
      if (AHI_W < 1 || AHI_W > 16)    begin : g_bad_ahi_w  $error("upper address must fit 16 bits"); end
      if (NUM_DATA < 1 || NUM_DATA > 2) begin : g_bad_nd   $error("one or two data words"); end
      if (CSAI_W < 1 || CSAI_W > 8)   begin : g_bad_csai_w $error("completion SAI must fit 8 bits"); end
      if (REG_AW < 4)                 begin : g_bad_aw     $error("register index needs 4 bits"); end
   endgenerate

   localparam logic [REG_AW-1:0] A_HDR     = REG_AW'(OFS_HDR);
   localparam logic [REG_AW-1:0] A_ADDR_LO = REG_AW'(OFS_ADDR_LO);
   localparam logic [REG_AW-1:0] A_ADDR_HI = REG_AW'(OFS_ADDR_HI);
   localparam logic [REG_AW-1:0] A_EXT     = REG_AW'(OFS_EXT);
   localparam logic [REG_AW-1:0] A_DATA0   = REG_AW'(OFS_DATA0);
   localparam logic [REG_AW-1:0] A_DATA1   = REG_AW'(OFS_DATA1);
   localparam logic [REG_AW-1:0] A_CTRL    = REG_AW'(OFS_CTRL);
   localparam logic [REG_AW-1:0] A_CPL_CTL = REG_AW'(OFS_CPL_CTL);
   localparam logic [REG_AW-1:0] A_CPL_DAT = REG_AW'(OFS_CPL_DAT);

   rx_kind_e              cap_kind;
   logic [PID_W-1:0]      cap_dst, cap_src;
   logic [7:0]            cap_opcode;
   logic [3:0]            cap_be;
   logic [DATA_W-1:0]     cap_addr_lo, cap_data0, cap_data1;
   logic [AHI_W-1:0]      cap_addr_hi;
   logic                  cap_wide, cap_eh;
   logic [SAI_W-1:0]      cap_sai;
   logic [RS_W-1:0]       cap_rs;
   logic                  access_en, irq_mask, rcv_sts, start_cpl, cpl_busy, accept;
   logic [2:0]            code_q;
   logic [DATA_W-1:0]     cdata_q;

   assign req_ready = access_en && !rcv_sts && !cpl_busy;
   assign accept    = req_valid && req_ready;

   sbir_capture #(
      .PID_W(PID_W), .SAI_W(SAI_W), .RS_W(RS_W), .AHI_W(AHI_W),
      .DATA_W(DATA_W), .NUM_DATA(NUM_DATA)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .in_kind(req_kind), .in_dst(req_dst), .in_src(req_src),
      .in_opcode(req_opcode), .in_be(req_be), .in_addr_lo(req_addr_lo),
      .in_addr_hi(req_addr_hi), .in_wide(req_addr_wide), .in_sai(req_sai),
      .in_rs(req_rs), .in_eh(req_eh), .in_data0(req_data0), .in_data1(req_data1),
      .cap_kind(cap_kind), .cap_dst(cap_dst), .cap_src(cap_src),
      .cap_opcode(cap_opcode), .cap_be(cap_be), .cap_addr_lo(cap_addr_lo),
      .cap_addr_hi(cap_addr_hi), .cap_wide(cap_wide), .cap_sai(cap_sai),
      .cap_rs(cap_rs), .cap_eh(cap_eh), .cap_data0(cap_data0), .cap_data1(cap_data1)
   );

   sbir_ctrl #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_sel && bus_wr), .wr_addr(bus_addr),
      .wdata(bus_wdata), .accept(accept), .cpl_busy(cpl_busy), .rx_kind(cap_kind),
      .access_en(access_en), .irq_mask(irq_mask), .rcv_sts(rcv_sts),
      .cpl_code(code_q), .cpl_word(cdata_q), .start_cpl(start_cpl)
   );

   sbir_cpl_engine u_cpl (
      .clk(clk), .rst_n(rst_n), .start(start_cpl), .out_ready(cpl_ready),
      .out_valid(cpl_valid), .busy(cpl_busy)
   );

   assign cpl_dst  = cap_src;
   assign cpl_code = code_q;
   assign cpl_data = cdata_q;
   assign cpl_sai  = CPL_SAI[CSAI_W-1:0];
   assign irq      = rcv_sts && !irq_mask;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_HDR: begin
            bus_rdata[0 +: PID_W]  = cap_dst;
            bus_rdata[8 +: PID_W]  = cap_src;
            bus_rdata[23:16]       = cap_opcode;
            bus_rdata[27:24]       = cap_be;
            bus_rdata[29:28]       = cap_kind;
         end
         A_ADDR_LO: bus_rdata = cap_addr_lo;
         A_ADDR_HI: begin
            bus_rdata[0 +: AHI_W]  = cap_addr_hi;
            bus_rdata[31]          = cap_wide;
         end
         A_EXT: begin
            bus_rdata[0 +: SAI_W]  = cap_sai;
            bus_rdata[16 +: RS_W]  = cap_rs;
            bus_rdata[31]          = cap_eh;
         end
         A_DATA0: bus_rdata = cap_data0;
         A_DATA1: bus_rdata = cap_data1;
         A_CTRL: begin
            bus_rdata[0]           = access_en;
            bus_rdata[1]           = irq_mask;
            bus_rdata[31]          = rcv_sts;
         end
         A_CPL_CTL: begin
            bus_rdata[2:0]         = code_q;
            bus_rdata[TRIGGER_BIT] = cpl_busy;
         end
         A_CPL_DAT: bus_rdata = cdata_q;
         default:   bus_rdata = '0;
      endcase
   end

   assert_irq_implies_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> rcv_sts);
   assert_only_nonposted_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpl_valid) |-> cap_kind == KIND_NONPOSTED);
   assert_busy_closes_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> !req_ready);
   assert_cpl_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_dst) && $stable(cpl_code)
                                   && $stable(cpl_data));
   assert_held_message_closes_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_sts |-> !req_ready);

endmodule

// File: tb/sim_sb_inbound_responder.sv
module sim_sb_inbound_responder;

   localparam logic [7:0] SAI_FIX = 8'hA5;

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  dst, src, opc;
      logic [3:0]  be;
      logic [31:0] alo;
      logic [15:0] ahi;
      logic        wide;
      logic [15:0] sai;
      logic [3:0]  rs;
      logic        eh;
      logic [31:0] d0, d1;
   } req_t;

   typedef struct packed {
      logic [7:0]  dst;
      logic [7:0]  sai;
      logic [2:0]  code;
      logic [31:0] data;
   } cpl_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, cpl_ready = 1, bus_sel = 0, bus_wr = 0;
   logic req_ready, cpl_valid, irq;
   logic [1:0]  req_kind = 0;
   logic [7:0]  req_dst = 0, req_src = 0, req_opcode = 0;
   logic [3:0]  req_be = 0, req_rs = 0;
   logic [31:0] req_addr_lo = 0, req_data0 = 0, req_data1 = 0, bus_wdata = 0;
   logic [15:0] req_addr_hi = 0, req_sai = 0;
   logic        req_addr_wide = 0, req_eh = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_rdata, cpl_data;
   logic [7:0]  cpl_dst, cpl_sai;
   logic [2:0]  cpl_code;

   int checks = 0, fails = 0;
   cpl_t exp_q[$];
   req_t last_req;
   logic [31:0] cur_cdata = 0;

   always #5 clk = ~clk;

   sb_inbound_responder u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_dst(req_dst), .req_src(req_src), .req_opcode(req_opcode),
      .req_be(req_be), .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
      .req_addr_wide(req_addr_wide), .req_sai(req_sai), .req_rs(req_rs), .req_eh(req_eh),
      .req_data0(req_data0), .req_data1(req_data1), .cpl_valid(cpl_valid),
      .cpl_ready(cpl_ready), .cpl_dst(cpl_dst), .cpl_code(cpl_code), .cpl_data(cpl_data),
      .cpl_sai(cpl_sai), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #2 d = bus_rdata;
   endtask

   task automatic put_req(input req_t r);
      req_kind = r.kind; req_dst = r.dst; req_src = r.src; req_opcode = r.opc;
      req_be = r.be; req_addr_lo = r.alo; req_addr_hi = r.ahi; req_addr_wide = r.wide;
      req_sai = r.sai; req_rs = r.rs; req_eh = r.eh; req_data0 = r.d0; req_data1 = r.d1;
      req_valid = 1;
   endtask

   // driver: present a request and wait for it to be taken
   task automatic send_req(input req_t r);
      @(negedge clk);
      put_req(r);
      forever begin
         #2;
         if (req_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      req_valid = 0;
      last_req = r;
   endtask

   task automatic set_cdata(input logic [31:0] d);
      reg_wr(4'd8, d);
      cur_cdata = d;
   endtask

   // firmware retire; pushes the completion the requirements predict
   task automatic retire(input logic [2:0] code, input logic held);
      if (held && last_req.kind == 2'b10)
         exp_q.push_back('{dst: last_req.src, sai: SAI_FIX, code: code, data: cur_cdata});
      reg_wr(4'd7, 32'h8000_0000 | {29'd0, code});
   endtask

   task automatic check_capture(input req_t r, input string tag);
      logic [31:0] v;
      reg_rd(4'd0, v); chk({tag, " header"}, v, {2'b00, r.kind, r.be, r.opc, r.src, r.dst});
      reg_rd(4'd1, v); chk({tag, " addr lo"}, v, r.alo);
      reg_rd(4'd2, v); chk({tag, " addr hi"}, v, {r.wide, 15'd0, r.ahi});
      reg_rd(4'd3, v); chk({tag, " ext"}, v, {r.eh, 11'd0, r.rs, r.sai});
      reg_rd(4'd4, v); chk({tag, " data0"}, v, r.d0);
      reg_rd(4'd5, v); chk({tag, " data1"}, v, r.d1);
   endtask

   // monitor: compares each completion handshake with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && cpl_valid && cpl_ready) begin
            if (exp_q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R7: unexpected completion actual %h expected none",
                        {cpl_dst, cpl_sai, cpl_code, cpl_data});
            end else begin
               cpl_t e;
               e = exp_q.pop_front();
               chk("R6 completion content", {cpl_dst, cpl_sai, cpl_code, cpl_data}, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      req_t ra, rb, rc, rd, re, rf;
      ra = '{kind:2'b01, dst:8'h11, src:8'h22, opc:8'h33, be:4'hF, alo:32'hDEAD_BEEF,
             ahi:16'h1234, wide:1, sai:16'hC0DE, rs:4'h5, eh:1, d0:32'hA1A1_A1A1, d1:32'hB2B2_B2B2};
      rb = '{kind:2'b10, dst:8'h44, src:8'h55, opc:8'h66, be:4'h3, alo:32'h0000_0100,
             ahi:16'h0, wide:0, sai:16'h0, rs:4'h0, eh:0, d0:32'h1111_2222, d1:32'h3333_4444};
      rc = '{kind:2'b10, dst:8'h70, src:8'h71, opc:8'h72, be:4'h1, alo:32'h0000_0ABC,
             ahi:16'hFFFF, wide:1, sai:16'h8001, rs:4'hF, eh:1, d0:32'h5, d1:32'h6};
      rd = '{kind:2'b10, dst:8'h80, src:8'h81, opc:8'h82, be:4'h8, alo:32'h1,
             ahi:16'h2, wide:0, sai:16'h3, rs:4'h4, eh:0, d0:32'h7, d1:32'h8};
      re = '{kind:2'b01, dst:8'h90, src:8'h91, opc:8'h92, be:4'h2, alo:32'h9,
             ahi:16'h9, wide:1, sai:16'h9, rs:4'h9, eh:1, d0:32'h9, d1:32'h9};
      rf = '{kind:2'b11, dst:8'hA0, src:8'hA1, opc:8'hA2, be:4'h4, alo:32'hAA,
             ahi:16'hAB, wide:0, sai:16'hAC, rs:4'h2, eh:1, d0:32'hAD, d1:32'hAE};

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 req_ready", req_ready, 0);
      chk("R1 irq", irq, 0);
      chk("R1 cpl_valid", cpl_valid, 0);
      reg_rd(4'd0, v); chk("R1 header", v, 0);
      reg_rd(4'd6, v); chk("R1 ctrl", v, 0);
      rst_n = 1;
      reg_rd(4'd6, v); chk("R1 ctrl after release", v, 0);

      // R2 closed port: request is ignored
      @(negedge clk); put_req(ra);
      repeat (3) @(negedge clk);
      #2 chk("R2 ready while disabled", req_ready, 0);
      req_valid = 0;
      reg_rd(4'd0, v); chk("R2 header untouched", v, 0);
      reg_rd(4'd6, v); chk("R2 status untouched", v, 0);

      // R3/R4/R5 posted capture
      reg_wr(4'd6, 32'h1);
      #2 chk("R2 ready when enabled", req_ready, 1);
      send_req(ra);
      check_capture(ra, "R3 posted");
      reg_rd(4'd6, v); chk("R4 status set", v, 32'h8000_0001);
      chk("R5 irq raised", irq, 1);
      chk("R4 ready low", req_ready, 0);
      @(negedge clk); put_req(re);
      repeat (3) @(negedge clk);
      #2 chk("R4 ready low with pending", req_ready, 0);
      req_valid = 0;
      reg_rd(4'd0, v); chk("R4 header not overwritten", v, {2'b00, ra.kind, ra.be, ra.opc, ra.src, ra.dst});
      reg_wr(4'd6, 32'h3);
      #2 chk("R5 irq masked", irq, 0);
      reg_rd(4'd6, v); chk("R5 status kept under mask", v, 32'h8000_0003);
      reg_wr(4'd6, 32'h1);
      #2 chk("R5 irq unmasked", irq, 1);

      // R7 posted retire: no completion
      retire(3'b000, 1);
      reg_rd(4'd6, v); chk("R7 status cleared posted", v, 32'h1);
      chk("R7 no completion posted", cpl_valid, 0);
      chk("R5 irq cleared", irq, 0);

      // R6 non-posted with immediate acceptance
      set_cdata(32'hCAFE_F00D);
      send_req(rb);
      check_capture(rb, "R3 nonposted");
      retire(3'b001, 1);
      reg_rd(4'd6, v); chk("R6 status cleared", v, 32'h1);
      repeat (2) @(negedge clk);
      chk("R6 completion drained", exp_q.size(), 0);

      // R8 stalled completion
      cpl_ready = 0;
      set_cdata(32'h0BAD_0BAD);
      send_req(rc);
      retire(3'b000, 1);
      chk("R8 valid during stall", cpl_valid, 1);
      reg_rd(4'd7, v); chk("R8 busy bit", v, 32'h8000_0000);
      reg_wr(4'd8, 32'h1234_5678);
      reg_wr(4'd7, 32'h0000_0001);
      #2 chk("R8 data frozen", cpl_data, 32'h0BAD_0BAD);
      chk("R8 code frozen", cpl_code, 3'b000);
      @(negedge clk); put_req(rd);
      repeat (2) @(negedge clk);
      #2 chk("R8 port closed while busy", req_ready, 0);
      req_valid = 0;
      reg_rd(4'd0, v); chk("R8 no capture while busy", v, {2'b00, rc.kind, rc.be, rc.opc, rc.src, rc.dst});
      @(negedge clk); cpl_ready = 1;
      repeat (2) @(negedge clk);
      reg_rd(4'd7, v); chk("R8 busy cleared", v, 32'h0);
      chk("R8 drained", exp_q.size(), 0);
      #2 chk("R8 port reopens", req_ready, 1);

      // R9 trigger with nothing held
      retire(3'b000, 0);
      repeat (2) @(negedge clk);
      chk("R9 no completion", cpl_valid, 0);
      reg_rd(4'd6, v); chk("R9 status stays clear", v, 32'h1);

      // R7 completion-kind retire, R3 with another pattern
      send_req(rf);
      check_capture(rf, "R3 completion kind");
      retire(3'b000, 1);
      repeat (2) @(negedge clk);
      chk("R7 no completion for kind 11", cpl_valid, 0);
      reg_rd(4'd6, v); chk("R7 status cleared kind 11", v, 32'h1);

      // R6 second non-posted with success code after prior ones
      set_cdata(32'h0000_0042);
      send_req(rd);
      retire(3'b000, 1);
      repeat (3) @(negedge clk);
      chk("R6 scoreboard empty", exp_q.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule